// File: doc/BRIEF.md
# Vectored Interrupt Bitmap File

This block keeps the per-vector state of a 256-vector interrupt controller as four 256-bit bitmaps. The request bitmap marks vectors waiting for service. The in-service bitmap marks vectors that have been handed to the processor. The trigger-mode bitmap records whether each accepted request was level or edge triggered. The enable bitmap decides which vectors may be requested at all.

Requesters use a raise port and a lower port, each carrying an 8-bit vector. The block reports whether any request is pending and which vector is the highest pending one, both in the same cycle. A begin-service strobe moves that highest vector from the request bitmap into the in-service bitmap in a single update.

A 32-bit register port reads every bitmap word by word. It can also rewrite the enable bitmap. Vectors 0 to 15 are reserved: raising one of them is refused and flagged.

Top module: `vec_irq_bitmap`

## Requirements
- R1: After reset the enable bitmap is all ones, and the request, in-service and trigger-mode bitmaps are all zeros, so `pend` is 0.
- R2: A raise of a vector below 16 pulses `raise_err` in the cycle after the raise and sets no request bit.
- R3: A raise of a vector of 16 or above whose enable bit is 0 changes no bitmap and does not pulse `raise_err`.
- R4: A raise of a vector of 16 or above whose enable bit is 1 sets its request bit. It also writes `raise_level` into its trigger-mode bit. Both are visible from the cycle after the raise.
- R5: A lower clears the request bit of its vector. When a raise and a lower name the same vector in one cycle, the bit ends up cleared.
- R6: `pend` is 1 exactly when at least one request bit is set.
- R7: `top_vec` gives the highest-numbered set request bit, and it is valid in the same cycle as `pend`.
- R8: While `pend` is 1, `svc_req` sets the in-service bit of `top_vec` and clears its request bit in the same clock edge. While `pend` is 0, `svc_req` has no effect.
- R9: A read (`reg_en`=1, `reg_wr`=0) returns word w of a bitmap on `reg_rdata` in the next cycle, with `reg_err` 0. Word w sits at byte address base + 0x10*w for w = 0..7. The bases are: in-service 0x100, trigger mode 0x180, request 0x200, enable 0x480. Bit b of word w is vector 32*w + b.
- R10: A write to an enable word replaces those 32 enable bits from the next cycle.
- R11: A write to a request, in-service or trigger-mode word changes nothing and pulses `reg_err` in the next cycle. Any access to an address outside the four bitmaps, or with address bits [3:0] non-zero, does the same and returns 0 data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_valid | input | 1 | Raise request strobe |
| raise_vec | input | 8 | Vector to raise |
| raise_level | input | 1 | Trigger mode to record: 1 level, 0 edge |
| raise_err | output | 1 | Pulses after a raise of a reserved vector |
| lower_valid | input | 1 | Lower request strobe |
| lower_vec | input | 8 | Vector to lower |
| svc_req | input | 1 | Begin service of the highest pending vector |
| pend | output | 1 | Any request bit set |
| top_vec | output | 8 | Highest pending vector |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 write, 0 read |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the access |
| reg_err | output | 1 | Access error, one cycle after the access |

## Verification
The first pattern raises and lowers every vector 0 to 255 on its own. This separates the reserved range from the accepted range and checks each bit's position in the register words. The second pattern raises vectors in ascending order so that each new request must become `top_vec`. Servicing them all afterwards must pull them out in strictly descending order, and a final strobe on an empty bitmap must change nothing. A partial enable mask tells a disabled raise apart from an accepted one. Further cases cover a raise and lower of the same vector in one cycle, writes to the read-only words, and misaligned or unmapped addresses.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
    localparam int VEC_N     = 256;
    localparam int VEC_W     = $clog2(VEC_N);
    localparam int WORD_W    = 32;
    localparam int WORDS     = VEC_N / WORD_W;
    localparam int WIDX_W    = $clog2(WORDS);
    localparam int ADDR_W    = 12;
    localparam int FIRST_OK  = 16;
    localparam int STRIDE_LG = 4;
    localparam int GRP_LG    = STRIDE_LG + WIDX_W;

    localparam logic [ADDR_W-1:0] BASE_SVC  = 12'h100;
    localparam logic [ADDR_W-1:0] BASE_TRIG = 12'h180;
    localparam logic [ADDR_W-1:0] BASE_REQ  = 12'h200;
    localparam logic [ADDR_W-1:0] BASE_ENA  = 12'h480;

    typedef enum logic [1:0] {
        MAP_SVC  = 2'd0,
        MAP_TRIG = 2'd1,
        MAP_REQ  = 2'd2,
        MAP_ENA  = 2'd3
    } map_sel_e;

    typedef struct packed {
        logic [VEC_N-1:0]  req;
        logic [VEC_N-1:0]  svc;
        logic [VEC_N-1:0]  trig;
        logic [VEC_N-1:0]  ena;
        logic [WORD_W-1:0] rdata;
        logic              reg_err;
        logic              raise_err;
    } bm_state_t;
endpackage

// File: rtl/vec_prio_enc.sv
module vec_prio_enc
    import vec_irq_pkg::*;
#(
    parameter int N     = VEC_N,
    parameter int GRP   = WORD_W,
    localparam int IW   = $clog2(N),
    localparam int NG   = N / GRP,
    localparam int GW   = $clog2(GRP)
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [NG-1:0]        grp_any;
    logic [GW-1:0]        grp_idx [NG];

    for (genvar g = 0; g < NG; g++) begin : g_grp
        always_comb begin
            grp_any[g] = |bits[g*GRP +: GRP];
            grp_idx[g] = '0;
            for (int b = 0; b < GRP; b++) begin
                if (bits[g*GRP + b]) grp_idx[g] = GW'(b);
            end
        end
    end

    always_comb begin
        any = |grp_any;
        idx = '0;
        for (int g = 0; g < NG; g++) begin
            if (grp_any[g]) idx = IW'(g * GRP) | IW'(grp_idx[g]);
        end
    end
endmodule

// File: rtl/vec_reg_decode.sv
module vec_reg_decode
    import vec_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output map_sel_e          sel,
    output logic [WIDX_W-1:0] widx
);
    logic [ADDR_W-GRP_LG-1:0] grp;

    always_comb begin
        grp  = addr[ADDR_W-1:GRP_LG];
        widx = addr[GRP_LG-1:STRIDE_LG];
        hit  = (addr[STRIDE_LG-1:0] == '0);
        sel  = MAP_SVC;
        if (grp == BASE_SVC[ADDR_W-1:GRP_LG])       sel = MAP_SVC;
        else if (grp == BASE_TRIG[ADDR_W-1:GRP_LG]) sel = MAP_TRIG;
        else if (grp == BASE_REQ[ADDR_W-1:GRP_LG])  sel = MAP_REQ;
        else if (grp == BASE_ENA[ADDR_W-1:GRP_LG])  sel = MAP_ENA;
        else                                        hit = 1'b0;
    end
endmodule

// File: rtl/vec_irq_bitmap.sv
module vec_irq_bitmap
    import vec_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_valid,
    input  logic [VEC_W-1:0]  raise_vec,
    input  logic              raise_level,
    output logic              raise_err,
    input  logic              lower_valid,
    input  logic [VEC_W-1:0]  lower_vec,
    input  logic              svc_req,
    output logic              pend,
    output logic [VEC_W-1:0]  top_vec,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              reg_err
);
    bm_state_t         st_d, st_q;
    logic              dec_hit;
    map_sel_e          dec_sel;
    logic [WIDX_W-1:0] dec_widx;
    logic [VEC_N-1:0]  set_m, clr_m, sel_map;

    // Signals brought out for the bound checker
    logic [VEC_N-1:0]  req_map, svc_map, ena_map;
    assign req_map = st_q.req;
    assign svc_map = st_q.svc;
    assign ena_map = st_q.ena;

    vec_prio_enc #(.N(VEC_N), .GRP(WORD_W)) u_enc (
        .bits (st_q.req),
        .any  (pend),
        .idx  (top_vec)
    );

    vec_reg_decode u_dec (
        .addr (reg_addr),
        .hit  (dec_hit),
        .sel  (dec_sel),
        .widx (dec_widx)
    );

    always_comb begin
        unique case (dec_sel)
            MAP_SVC:  sel_map = st_q.svc;
            MAP_TRIG: sel_map = st_q.trig;
            MAP_REQ:  sel_map = st_q.req;
            default:  sel_map = st_q.ena;
        endcase
    end

    always_comb begin
        st_d           = st_q;
        st_d.raise_err = 1'b0;
        st_d.reg_err   = 1'b0;
        st_d.rdata     = '0;
        set_m          = '0;
        clr_m          = '0;

        if (raise_valid) begin
            if (int'(raise_vec) < FIRST_OK) begin
                st_d.raise_err = 1'b1;
            end else if (st_q.ena[raise_vec]) begin
                set_m[raise_vec]     = 1'b1;
                st_d.trig[raise_vec] = raise_level;
            end
        end

        if (lower_valid) clr_m[lower_vec] = 1'b1;

        if (svc_req && pend) begin
            clr_m[top_vec]    = 1'b1;
            st_d.svc[top_vec] = 1'b1;
        end

        st_d.req = (st_q.req | set_m) & ~clr_m;

        if (reg_en) begin
            if (!dec_hit) begin
                st_d.reg_err = 1'b1;
            end else if (reg_wr) begin
                if (dec_sel == MAP_ENA)
                    st_d.ena[{dec_widx, 5'b0} +: WORD_W] = reg_wdata;
                else
                    st_d.reg_err = 1'b1;
            end else begin
                st_d.rdata = sel_map[{dec_widx, 5'b0} +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ena  <= '1;
        end else begin
            st_q      <= st_d;
        end
    end

    assign raise_err = st_q.raise_err;
    assign reg_rdata = st_q.rdata;
    assign reg_err   = st_q.reg_err;
endmodule

// File: rtl/vec_irq_bitmap_chk.sv
module vec_irq_bitmap_chk
    import vec_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             raise_valid,
    input logic [VEC_W-1:0] raise_vec,
    input logic             raise_err,
    input logic             lower_valid,
    input logic [VEC_W-1:0] lower_vec,
    input logic             svc_req,
    input logic             pend,
    input logic [VEC_W-1:0] top_vec,
    input logic [VEC_N-1:0] req_map,
    input logic [VEC_N-1:0] svc_map,
    input logic [VEC_N-1:0] ena_map
);
    logic             lo_v, ign_v, sv_v;
    logic [VEC_W-1:0] lo_vec, ign_vec, sv_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_v <= 1'b0; ign_v <= 1'b0; sv_v <= 1'b0;
            lo_vec <= '0; ign_vec <= '0; sv_vec <= '0;
        end else begin
            lo_v    <= lower_valid;
            lo_vec  <= lower_vec;
            ign_v   <= raise_valid && int'(raise_vec) >= FIRST_OK && !ena_map[raise_vec]
                       && !req_map[raise_vec];
            ign_vec <= raise_vec;
            sv_v    <= svc_req && pend;
            sv_vec  <= top_vec;
        end
    end

    AST_LOW_VEC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        raise_valid && int'(raise_vec) < FIRST_OK |=> raise_err); // R2
    AST_LOW_VEC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        req_map[FIRST_OK-1:0] == '0); // R2
    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ign_v |-> !req_map[ign_vec]); // R3
    AST_LOWER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        lo_v |-> !req_map[lo_vec]); // R5
    AST_PEND_HAS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> req_map[top_vec]); // R7
    AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> req_map == '0); // R6
    AST_SVC_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        sv_v |-> svc_map[sv_vec] && !req_map[sv_vec]); // R8
endmodule

bind vec_irq_bitmap vec_irq_bitmap_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .raise_valid (raise_valid),
    .raise_vec   (raise_vec),
    .raise_err   (raise_err),
    .lower_valid (lower_valid),
    .lower_vec   (lower_vec),
    .svc_req     (svc_req),
    .pend        (pend),
    .top_vec     (top_vec),
    .req_map     (req_map),
    .svc_map     (svc_map),
    .ena_map     (ena_map)
);

// File: tb/tb_vec_irq_bitmap.sv
`timescale 1ns/1ps
module tb_vec_irq_bitmap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_valid = 0, raise_level = 0, lower_valid = 0, svc_req = 0;
    logic [7:0]  raise_vec = 0, lower_vec = 0, top_vec;
    logic        raise_err, pend, reg_err;
    logic        reg_en = 0, reg_wr = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;

    int n_tests = 0, n_fail = 0;
    logic [255:0] m_req, m_svc, m_trig, m_ena;

    always #2 clk = ~clk;

    vec_irq_bitmap dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] model_top();
        logic [8:0] r = 9'h0;
        for (int i = 0; i < 256; i++) if (m_req[i]) r = {1'b1, 8'(i)};
        return r;
    endfunction

    task automatic chk_top(input string tag);
        logic [8:0] t = model_top();
        chk({tag, " R6 pend"}, 32'(pend), 32'(t[8]));
        if (t[8]) chk({tag, " R7 top_vec"}, 32'(top_vec), 32'(t[7:0]));
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic raise(input int v, input logic lvl);
        raise_valid = 1; raise_vec = 8'(v); raise_level = lvl;
        tick();
        raise_valid = 0;
        if (v < 16) chk("R2 raise_err", 32'(raise_err), 1);
        else begin
            chk("R3 raise_err quiet", 32'(raise_err), 0);
            if (m_ena[v]) begin m_req[v] = 1'b1; m_trig[v] = lvl; end
        end
    endtask

    task automatic lower(input int v);
        lower_valid = 1; lower_vec = 8'(v);
        tick();
        lower_valid = 0;
        m_req[v] = 1'b0;
    endtask

    task automatic svc();
        logic [8:0] t = model_top();
        svc_req = 1;
        tick();
        svc_req = 0;
        if (t[8]) begin m_req[t[7:0]] = 1'b0; m_svc[t[7:0]] = 1'b1; end
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp, input logic experr);
        reg_en = 1; reg_wr = 0; reg_addr = a;
        tick();
        reg_en = 0;
        chk({tag, " err"}, 32'(reg_err), 32'(experr));
        chk({tag, " data"}, reg_rdata, experr ? 32'h0 : exp);
    endtask

    task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d, input logic experr);
        reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_en = 0; reg_wr = 0;
        chk({tag, " err"}, 32'(reg_err), 32'(experr));
        if (!experr && a[11:7] == 5'h09) m_ena[{a[6:4], 5'b0} +: 32] = d;
    endtask

    task automatic cmp_all(input string tag);
        for (int w = 0; w < 8; w++) begin
            rd({tag, " R9 svc"},  12'h100 + 12'(w*16), m_svc[w*32 +: 32], 0);
            rd({tag, " R9 trig"}, 12'h180 + 12'(w*16), m_trig[w*32 +: 32], 0);
            rd({tag, " R9 req"},  12'h200 + 12'(w*16), m_req[w*32 +: 32], 0);
            rd({tag, " R9 ena"},  12'h480 + 12'(w*16), m_ena[w*32 +: 32], 0);
        end
    endtask

    initial begin
        #400000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_req = '0; m_svc = '0; m_trig = '0; m_ena = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pend", 32'(pend), 0);
        cmp_all("R1");

        // R2/R4/R5/R9 single-vector sweep
        for (int v = 0; v < 256; v++) begin
            raise(v, v[0]);
            chk_top("R4 single");
            if (v >= 16) rd("R4 R9 req word", 12'h200 + 12'((v/32)*16), 32'(1) << (v%32), 0);
            lower(v);
            chk("R5 pend after lower", 32'(pend), 0);
        end
        cmp_all("R4 trig");

        // R7 ascending raise: each new one becomes top
        for (int v = 16; v < 256; v++) begin
            raise(v, 1'b0);
            chk("R7 ascending top", 32'(top_vec), 32'(v));
        end

        // R8 service sweep: descending order
        for (int k = 0; k < 240; k++) begin
            chk("R8 next top", 32'(top_vec), 32'(255 - k));
            svc();
        end
        chk("R8 drained", 32'(pend), 0);
        svc();
        cmp_all("R8 empty svc");

        // R10 / R3 enable mask
        wr("R10 ena write", 12'h4a0, 32'h0000ffff, 0);
        rd("R10 ena readback", 12'h4a0, 32'h0000ffff, 0);
        raise(80, 1'b1);
        chk("R3 disabled raise", 32'(pend), 0);
        raise(70, 1'b1);
        chk_top("R10 enabled raise");
        cmp_all("R3 after mask");

        // R5 raise and lower same vector same cycle
        raise_valid = 1; raise_vec = 8'd200; lower_valid = 1; lower_vec = 8'd200;
        tick();
        raise_valid = 0; lower_valid = 0;
        m_trig[200] = raise_level;
        chk("R5 lower wins", 32'(pend), 1);
        chk("R5 lower wins top", 32'(top_vec), 70);

        // R11 read-only, unmapped, misaligned
        wr("R11 req write", 12'h200, 32'hffffffff, 1);
        wr("R11 svc write", 12'h110, 32'hffffffff, 1);
        wr("R11 trig write", 12'h1f0, 32'hffffffff, 1);
        rd("R11 unmapped", 12'h300, 0, 1);
        rd("R11 misaligned", 12'h104, 0, 1);
        wr("R11 misaligned ena", 12'h484, 32'h0, 1);
        cmp_all("R11 unchanged");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule